// File: doc/BRIEF.md
# I2C Bit-Level Bus Engine

This block moves an open-drain I2C bus one primitive at a time. A controller above it hands over one of four operations per handshake: open a transaction (or reopen one that is already running, which gives a repeated start), close it, shift one bit out, or shift one bit in. The engine never drives a line high. It only pulls SCL or SDA low or lets it go, and it reads both wires back through two-flop synchronisers.

Every line change is spaced by a programmable step of `STEP_CYCLES` clock cycles. The nominal step is 5 µs, so the default of 1000 assumes a 200 MHz clock. Whenever the engine lets SCL go, it waits until the synchronised SCL actually reads high, so a target can stretch the clock. If that wait lasts `STRETCH_LIMIT` cycles, the operation is abandoned and a timeout flag is raised. When the engine sends a 1 but finds SDA low during the high phase of the clock, it flags lost arbitration.

The engine remembers whether a transaction is open. That memory turns an open command into a repeated start when needed. `STEP_CYCLES` must be at least 3 and `STRETCH_LIMIT` at least 4.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, both lines are released, `txn_open` is 0, `cmd_ready` is 1, and `done`, `arb_lost` and `timeout` are 0.
- R2: Opcodes on `cmd_op` are 0 open, 1 close, 2 send bit, 3 receive bit. With no transaction open, an open command pulls SDA low while SCL is high and holds it for one step. It then pulls SCL low and sets `txn_open`. `done` is seen `STEP_CYCLES` cycles after acceptance.
- R3: With a transaction open, an open command releases SDA and waits a step. It then releases SCL, waits for SCL high and waits a step. Finally it makes the SDA falling edge while SCL is high, as in R2. With no stretching, `done` follows acceptance by 3·STEP_CYCLES+3 cycles.
- R4: A close command pulls SDA low and waits a step. It releases SCL, waits for SCL high and waits a step. It then releases SDA while SCL is high, waits a step and clears `txn_open`, leaving both lines released. This takes 3·STEP_CYCLES+3 cycles.
- R5: A send command puts `tx_bit` on SDA and waits a step. It releases SCL, waits for SCL high, waits a step and pulls SCL low again. SDA does not change while SCL is released. This takes 2·STEP_CYCLES+3 cycles.
- R6: A receive command releases SDA and waits a step. It releases SCL and, once SCL reads high, samples SDA into `rx_bit`. It then waits a step and pulls SCL low. This takes 2·STEP_CYCLES+3 cycles.
- R7: `arb_lost` is set when a sent 1 finds SDA low at the sampling point. A sent 0, a matching 1 and any receive leave it 0. Both `arb_lost` and `timeout` are cleared when the next command is accepted.
- R8: While a target holds SCL low after the release, the engine stays busy. `done` follows the SCL release by STEP_CYCLES+3 cycles, counting the two synchroniser stages.
- R9: If SCL has not read high `STRETCH_LIMIT` cycles after the release, the command ends with `done`, sets `timeout`, releases both lines and clears `txn_open`. For a send command, this happens STEP_CYCLES+STRETCH_LIMIT cycles after acceptance.
- R10: A command is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while an operation runs, so a command offered during that time is ignored. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Operation code (0 open, 1 close, 2 send, 3 receive) |
| tx_bit | input | 1 | Bit to send, taken with a send command |
| rx_bit | output | 1 | Last received bit |
| done | output | 1 | One-cycle pulse when an operation ends |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_in | input | 1 | SCL line level read back |
| sda_in | input | 1 | SDA line level read back |
| txn_open | output | 1 | A transaction is open |
| arb_lost | output | 1 | Last send of a 1 saw SDA low |
| timeout | output | 1 | Last operation was abandoned in a stretch wait |

## Verification
The bench builds the engine with `STEP_CYCLES` = 4 and `STRETCH_LIMIT` = 20. With these values every primitive finishes in a few tens of cycles, and each exact latency can be written as a small sum of step counts. They also make it cheap to sweep both bit operations over every combination of sent bit and target SDA level. A stretch can be held long enough to stay under the limit, and another long enough to cross it, in a handful of cycles. A bus monitor counts SDA edges while SCL is high, which shows that framing edges occur only for open and close commands.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

    typedef enum logic [1:0] {
        OP_OPEN  = 2'd0,
        OP_CLOSE = 2'd1,
        OP_SEND  = 2'd2,
        OP_RECV  = 2'd3
    } bit_op_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RE_FREE,
        SQ_RE_RISE,
        SQ_RE_HOLD,
        SQ_EDGE,
        SQ_CL_LOW,
        SQ_CL_RISE,
        SQ_CL_HOLD,
        SQ_CL_FREE,
        SQ_BIT_SET,
        SQ_BIT_RISE,
        SQ_BIT_HIGH
    } seq_state_e;

    // 1 in a field means the engine pulls that line low
    typedef struct packed {
        logic scl;
        logic sda;
    } line_pull_t;

    function automatic logic waits_step(seq_state_e s);
        return s inside {SQ_RE_FREE, SQ_RE_HOLD, SQ_EDGE, SQ_CL_LOW,
                         SQ_CL_HOLD, SQ_CL_FREE, SQ_BIT_SET, SQ_BIT_HIGH};
    endfunction

    function automatic logic waits_rise(seq_state_e s);
        return s inside {SQ_RE_RISE, SQ_CL_RISE, SQ_BIT_RISE};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2c_step_timer.sv
module i2c_step_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expired
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] RELOAD = W'(CYCLES - 1);

    logic [W-1:0] cnt;

    assign expired = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= RELOAD;
        else if (!active || expired) cnt <= RELOAD;
        else                         cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/i2c_stretch_guard.sv
module i2c_stretch_guard #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic waiting,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign expired = waiting && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !waiting)  cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_bit_pkg::*;
#(
    parameter int STEP_CYCLES   = 1000,
    parameter int STRETCH_LIMIT = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic       tx_bit,
    output logic       rx_bit,
    output logic       done,
    output logic       scl_pull,
    output logic       sda_pull,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       txn_open,
    output logic       arb_lost,
    output logic       timeout
);
    seq_state_e state;
    line_pull_t pull_q;
    bit_op_e    op_q;
    logic       tx_q;
    logic [1:0] seen;
    logic       scl_hi, sda_hi;
    logic       step_done, stretch_over;

    i2c_line_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .raw({scl_in, sda_in}), .synced(seen)
    );
    assign scl_hi = seen[1];
    assign sda_hi = seen[0];

    i2c_step_timer #(.CYCLES(STEP_CYCLES)) u_step (
        .clk(clk), .rst(rst), .active(waits_step(state)), .expired(step_done)
    );

    i2c_stretch_guard #(.LIMIT(STRETCH_LIMIT)) u_guard (
        .clk(clk), .rst(rst), .waiting(waits_rise(state)), .expired(stretch_over)
    );

    assign cmd_ready = (state == SQ_IDLE);
    assign scl_pull  = pull_q.scl;
    assign sda_pull  = pull_q.sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            pull_q   <= '0;
            op_q     <= OP_OPEN;
            tx_q     <= 1'b0;
            txn_open <= 1'b0;
            done     <= 1'b0;
            arb_lost <= 1'b0;
            timeout  <= 1'b0;
            rx_bit   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: if (cmd_valid) begin
                    arb_lost <= 1'b0;
                    timeout  <= 1'b0;
                    op_q     <= bit_op_e'(cmd_op);
                    tx_q     <= tx_bit;
                    case (bit_op_e'(cmd_op))
                        OP_OPEN: begin
                            if (txn_open) begin
                                pull_q.sda <= 1'b0;
                                state      <= SQ_RE_FREE;
                            end else begin
                                pull_q.sda <= 1'b1;
                                state      <= SQ_EDGE;
                            end
                        end
                        OP_CLOSE: begin
                            pull_q.sda <= 1'b1;
                            state      <= SQ_CL_LOW;
                        end
                        OP_SEND: begin
                            pull_q.sda <= !tx_bit;
                            state      <= SQ_BIT_SET;
                        end
                        default: begin
                            pull_q.sda <= 1'b0;
                            state      <= SQ_BIT_SET;
                        end
                    endcase
                end
                SQ_RE_FREE: if (step_done) begin
                    pull_q.scl <= 1'b0;
                    state      <= SQ_RE_RISE;
                end
                SQ_RE_RISE: if (scl_hi) state <= SQ_RE_HOLD;
                SQ_RE_HOLD: if (step_done) begin
                    pull_q.sda <= 1'b1;
                    state      <= SQ_EDGE;
                end
                SQ_EDGE: if (step_done) begin
                    pull_q.scl <= 1'b1;
                    txn_open   <= 1'b1;
                    done       <= 1'b1;
                    state      <= SQ_IDLE;
                end
                SQ_CL_LOW: if (step_done) begin
                    pull_q.scl <= 1'b0;
                    state      <= SQ_CL_RISE;
                end
                SQ_CL_RISE: if (scl_hi) state <= SQ_CL_HOLD;
                SQ_CL_HOLD: if (step_done) begin
                    pull_q.sda <= 1'b0;
                    state      <= SQ_CL_FREE;
                end
                SQ_CL_FREE: if (step_done) begin
                    txn_open <= 1'b0;
                    done     <= 1'b1;
                    state    <= SQ_IDLE;
                end
                SQ_BIT_SET: if (step_done) begin
                    pull_q.scl <= 1'b0;
                    state      <= SQ_BIT_RISE;
                end
                SQ_BIT_RISE: if (scl_hi) begin
                    if (op_q == OP_RECV)     rx_bit   <= sda_hi;
                    else if (tx_q && !sda_hi) arb_lost <= 1'b1;
                    state <= SQ_BIT_HIGH;
                end
                SQ_BIT_HIGH: if (step_done) begin
                    pull_q.scl <= 1'b1;
                    done       <= 1'b1;
                    state      <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
            if (stretch_over && !scl_hi) begin
                pull_q   <= '0;
                txn_open <= 1'b0;
                timeout  <= 1'b1;
                done     <= 1'b1;
                state    <= SQ_IDLE;
            end
        end
    end
endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic       done,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic       txn_open,
    input logic       timeout
);
    logic [1:0] last_op;

    always_ff @(posedge clk) begin
        if (rst)                         last_op <= 2'd0;
        else if (cmd_valid && cmd_ready) last_op <= cmd_op;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R2
    open_end_chk: assert property (@(posedge clk) disable iff (rst)
        (done && last_op == 2'd0 && !timeout) |-> (txn_open && scl_pull && sda_pull));

    // R4
    close_end_chk: assert property (@(posedge clk) disable iff (rst)
        (done && last_op == 2'd1 && !timeout) |-> (!txn_open && !scl_pull && !sda_pull));

    // R5
    bit_end_chk: assert property (@(posedge clk) disable iff (rst)
        (done && last_op[1] && !timeout) |-> scl_pull);

    // R5
    sda_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd_ready && last_op[1] && !scl_pull && !$past(scl_pull)) |-> $stable(sda_pull));

    // R9
    abort_free_chk: assert property (@(posedge clk) disable iff (rst)
        (done && timeout) |-> (!scl_pull && !sda_pull && !txn_open));
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .done(done), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .txn_open(txn_open), .timeout(timeout)
);

// File: tb/test_i2c_bit_engine.sv
`timescale 1ns/1ps
module test_i2c_bit_engine;
    localparam int STEP = 4;
    localparam int LIM  = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       tx_bit = 1'b0;
    logic       hold_scl = 1'b0;
    logic       slave_low = 1'b0;
    logic       cmd_ready, rx_bit, done, scl_pull, sda_pull, txn_open, arb_lost, timeout;
    logic       scl_in, sda_in;

    int checks = 0;
    int errors = 0;
    int start_ev = 0;
    int stop_ev = 0;
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;

    always #2.5 clk = ~clk;

    assign scl_in = !(scl_pull || hold_scl);
    assign sda_in = !(sda_pull || slave_low);

    i2c_bit_engine #(.STEP_CYCLES(STEP), .STRETCH_LIMIT(LIM)) i_i2c_bit_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .tx_bit(tx_bit), .rx_bit(rx_bit), .done(done),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .scl_in(scl_in), .sda_in(sda_in),
        .txn_open(txn_open), .arb_lost(arb_lost), .timeout(timeout)
    );

    always @(negedge clk) begin
        if (prev_scl && scl_in) begin
            if (prev_sda && !sda_in) start_ev++;
            if (!prev_sda && sda_in) stop_ev++;
        end
        prev_scl <= scl_in;
        prev_sda <= sda_in;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic tb, output int lat);
        @(negedge clk);
        cmd_op = op; tx_bit = tb; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat, s0, p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 txn_open", txn_open, 0);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 flags", {done, arb_lost, timeout}, 0);

        // R2 open from idle
        s0 = start_ev;
        run_cmd(2'd0, 1'b0, lat);
        chk("R2 latency", lat, STEP);
        chk("R2 start edge", start_ev - s0, 1);
        chk("R2 txn_open", txn_open, 1);
        chk("R2 lines", {scl_pull, sda_pull}, 3);

        // R5 R6 R7 sweep: bit op x sent bit x target SDA level
        for (int o = 2; o < 4; o++) begin
            for (int t = 0; t < 2; t++) begin
                for (int s = 0; s < 2; s++) begin
                    @(negedge clk);
                    slave_low = (s == 0);
                    s0 = start_ev; p0 = stop_ev;
                    run_cmd(2'(o), 1'(t), lat);
                    if (o == 2) chk("R5 send latency", lat, 2 * STEP + 3);
                    else        chk("R6 recv latency", lat, 2 * STEP + 3);
                    chk("R5 scl pulled at end", scl_pull, 1);
                    chk("R5 no framing edge", (start_ev - s0) + (stop_ev - p0), 0);
                    chk("R7 arb_lost", arb_lost, (o == 2 && t == 1 && s == 0) ? 1 : 0);
                    if (o == 3) chk("R6 rx_bit", rx_bit, s);
                    @(negedge clk);
                    slave_low = 1'b0;
                end
            end
        end

        // R7 flag cleared on next accepted command
        @(negedge clk);
        slave_low = 1'b1;
        run_cmd(2'd2, 1'b1, lat);
        chk("R7 arb set", arb_lost, 1);
        @(negedge clk);
        slave_low = 1'b0;
        run_cmd(2'd2, 1'b1, lat);
        chk("R7 arb cleared", arb_lost, 0);

        // R3 repeated start
        s0 = start_ev;
        run_cmd(2'd0, 1'b0, lat);
        chk("R3 latency", lat, 3 * STEP + 3);
        chk("R3 start edge", start_ev - s0, 1);
        chk("R3 txn_open", txn_open, 1);

        // R8 R10 stretch with a command offered while busy
        p0 = stop_ev;
        @(negedge clk);
        hold_scl = 1'b1;
        cmd_op = 2'd2; tx_bit = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'd1; cmd_valid = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 busy while held", {done, cmd_ready}, 0);
        chk("R10 ready low while busy", cmd_ready, 0);
        hold_scl = 1'b0;
        cmd_valid = 1'b0;
        lat = 0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 release to done", lat, STEP + 3);
        @(negedge clk);
        chk("R10 done single pulse", done, 0);
        chk("R10 busy command ignored", {txn_open, 1'(stop_ev - p0)}, 2);

        // R9 timeout
        @(negedge clk);
        hold_scl = 1'b1;
        run_cmd(2'd2, 1'b0, lat);
        chk("R9 latency", lat, STEP + LIM);
        chk("R9 timeout flag", timeout, 1);
        chk("R9 lines released", {scl_pull, sda_pull}, 0);
        chk("R9 txn_open", txn_open, 0);
        @(negedge clk);
        hold_scl = 1'b0;
        repeat (4) @(negedge clk);

        // R2 R7 open from idle again clears timeout
        s0 = start_ev;
        run_cmd(2'd0, 1'b0, lat);
        chk("R2 latency after abort", lat, STEP);
        chk("R7 timeout cleared", timeout, 0);
        chk("R2 start edge again", start_ev - s0, 1);

        // R4 close
        p0 = stop_ev;
        run_cmd(2'd1, 1'b0, lat);
        chk("R4 latency", lat, 3 * STEP + 3);
        chk("R4 stop edge", stop_ev - p0, 1);
        chk("R4 txn_open", txn_open, 0);
        chk("R4 lines released", {scl_pull, sda_pull}, 0);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule